// File: doc/BRIEF.md
# Dual Four-Mode Timer/Counter

This block holds two independent up-counting channels. Each one advances on a machine-cycle strobe (`tick_en`, one clock wide, asserted once per oscillator/12 period) or on falling edges of its own external event input. Software configures both channels through one shared mode register and one shared control/status register, and loads or reads the count bytes through a simple synchronous write port and a combinational read port. A channel counts only while its run bit is set. If its gate-enable bit is set, it also requires its gate input to be high, which lets the block measure the width of a high pulse.

Each channel offers four counting widths. There is a 13-bit counter, a 16-bit counter, an 8-bit counter that reloads itself from the high byte, and a split arrangement. The split arrangement exists only on channel 0. It turns channel 0 into two 8-bit counters, and the second of these takes over channel 1's overflow flag. Every hardware flag set also produces a one-cycle pulse on `ovf_o`, so a neighbouring interrupt controller can take the event.

Top module: `dual_mode_timer`

## Requirements
- R1: After reset, every register reads 0x00 (mode, control, and the four count bytes) and `ovf_o` is 0.
- R2: In mode 01 the channel's {high,low} bytes form a 16-bit counter. When the timer source is selected it rises by one on each `tick_en` while enabled. Going from 0xFFFF to 0x0000 sets that channel's flag.
- R3: Once set, a flag stays set until software writes 0 to it. The counter keeps counting after overflow. If software writes a flag in the same cycle that hardware sets it, the flag ends up set.
- R4: In mode 00, the low byte (8 bits) and the low 5 bits of the high byte form a 13-bit counter. It wraps from 0x1FFF to 0 and sets the flag. The high byte's upper 3 bits keep their value.
- R5: In mode 10 only the low byte counts. On a tick at 0xFF, the low byte is loaded with the high byte, the high byte is unchanged, and the flag is set.
- R6: When channel 0 is in mode 11, its low byte is an 8-bit counter under channel 0's run, gate and source controls, and its overflow sets flag 0. Its high byte counts machine cycles whenever run bit 1 is set, and its overflow sets flag 1.
- R7: While channel 0 is in mode 11, an overflow of channel 1 does not set flag 1. A channel 1 placed in mode 11 holds its count.
- R8: When a channel's gate-enable bit is 1, the channel counts only while its gate input is high. When the bit is 0, the gate input has no effect.
- R9: When a channel's source bit is 1, it counts one per falling edge of its external input. The input is synchronised and then sampled once per `tick_en`, so the count changes on the second machine cycle after the edge. A steady level, high or low, adds nothing.
- R10: A channel with its run bit at 0 holds its count.
- R11: The register addresses are 0 mode, 1 control, 2/3 channel 0 low/high, 4/5 channel 1 low/high, and other addresses read 0. Mode bits per channel are gate-enable, source, M1, M0 from high to low, with channel 0 in bits 3:0 and channel 1 in bits 7:4. Control bits 7..4 are flag1, run1, flag0, run0, software can write the flags to either value, and bits 3:0 read 0.
- R12: Every hardware flag set produces a one-cycle pulse on that channel's `ovf_o` bit, in the same cycle the flag becomes visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-clock strobe per machine cycle (oscillator/12) |
| ext_evt_i | input | 2 | Asynchronous external event inputs, one per channel |
| gate_i | input | 2 | Asynchronous gate inputs, active high, one per channel |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | 8 | Combinational read data |
| ovf_o | output | 2 | One-cycle pulse per hardware flag set, bit per channel |

## Verification
The bench targets the carry paths. A 13-bit counter that carries into all of the high byte would give 0x00 instead of 0xE0 in the high byte after the wrap, and a reload that copies the wrong byte or leaves the low byte at zero shows up after two ticks. In split mode the bench lets channel 1 overflow on purpose, so a design that still lets it raise flag 1 is caught, as is a channel 1 that keeps counting in mode 11. The bench also clears a flag in the same cycle as a wrap, holds the external input low for many ticks so that level-triggered counting is exposed, and toggles the gate during a run to confirm that counts stop and resume.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   localparam int unsigned BYTE_W = 8;
   localparam int unsigned W13_HI = 5;
   localparam int unsigned W13    = BYTE_W + W13_HI;
   localparam int unsigned NUM_CH = 2;

   typedef enum logic [1:0] {
      MD_W13    = 2'b00,
      MD_W16    = 2'b01,
      MD_RELOAD = 2'b10,
      MD_SPLIT  = 2'b11
   } tmr_mode_e;

   // register addresses
   localparam int unsigned A_MODE = 0;
   localparam int unsigned A_CTRL = 1;
   localparam int unsigned A_C0L  = 2;
   localparam int unsigned A_C0H  = 3;
   localparam int unsigned A_C1L  = 4;
   localparam int unsigned A_C1H  = 5;

   // control register bit positions (run bit of channel i at RUN0 + 2*i)
   localparam int unsigned CB_RUN0  = 4;
   localparam int unsigned CB_FLAG0 = 5;

endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic level_o
);

   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= async_i;
         end
      end else begin : g_many
         always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], async_i};
         end
      end
   endgenerate

   assign level_o = chain_q[STAGES-1];

endmodule

// File: rtl/tmr_edge_sampler.sv
module tmr_edge_sampler #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_en,
   input  logic async_i,
   output logic fall_o
);

   logic level;
   logic samp_q;
   logic prev_q;

   tmr_sync #(.STAGES(STAGES)) i_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .async_i(async_i),
      .level_o(level)
   );

   // one sample per machine cycle; a 1 followed by 0 is an event
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         samp_q <= 1'b0;
         prev_q <= 1'b0;
      end else if (tick_en) begin
         samp_q <= level;
         prev_q <= samp_q;
      end
   end

   assign fall_o = prev_q & ~samp_q;

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
   import tmr_pkg::*;
#(
   parameter bit CAN_SPLIT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  tmr_mode_e         mode_i,
   input  logic              step_i,
   input  logic              step_hi_i,
   input  logic              wr_lo_i,
   input  logic              wr_hi_i,
   input  logic [BYTE_W-1:0] wdata_i,
   output logic [BYTE_W-1:0] lo_o,
   output logic [BYTE_W-1:0] hi_o,
   output logic              wrap_o,
   output logic              wrap_hi_o
);

   logic [BYTE_W-1:0] lo_q, hi_q, lo_n, hi_n;
   logic [BYTE_W-1:0] split_lo, split_hi;
   logic              split_wrap_lo, split_wrap_hi;
   logic              wrap, wrap_hi;

   generate
      if (CAN_SPLIT) begin : g_split
         assign split_lo      = step_i    ? lo_q + 1'b1 : lo_q;
         assign split_hi      = step_hi_i ? hi_q + 1'b1 : hi_q;
         assign split_wrap_lo = step_i    & (&lo_q);
         assign split_wrap_hi = step_hi_i & (&hi_q);
      end else begin : g_frozen
         logic unused_step_hi;
         assign unused_step_hi = step_hi_i;
         assign split_lo       = lo_q;
         assign split_hi       = hi_q;
         assign split_wrap_lo  = 1'b0;
         assign split_wrap_hi  = 1'b0;
      end
   endgenerate

   always_comb begin
      lo_n    = lo_q;
      hi_n    = hi_q;
      wrap    = 1'b0;
      wrap_hi = 1'b0;
      unique case (mode_i)
         MD_W13: begin
            if (step_i) begin
               {hi_n[W13_HI-1:0], lo_n} = {hi_q[W13_HI-1:0], lo_q} + W13'(1);
               wrap = (&hi_q[W13_HI-1:0]) & (&lo_q);
            end
         end
         MD_W16: begin
            if (step_i) begin
               {hi_n, lo_n} = {hi_q, lo_q} + (2*BYTE_W)'(1);
               wrap = &{hi_q, lo_q};
            end
         end
         MD_RELOAD: begin
            if (step_i) begin
               if (&lo_q) begin
                  lo_n = hi_q;
                  wrap = 1'b1;
               end else begin
                  lo_n = lo_q + 1'b1;
               end
            end
         end
         MD_SPLIT: begin
            lo_n    = split_lo;
            hi_n    = split_hi;
            wrap    = split_wrap_lo;
            wrap_hi = split_wrap_hi;
         end
         default: ;
      endcase
      if (wr_lo_i) lo_n = wdata_i;
      if (wr_hi_i) hi_n = wdata_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
      end else begin
         lo_q <= lo_n;
         hi_q <= hi_n;
      end
   end

   assign lo_o      = lo_q;
   assign hi_o      = hi_q;
   assign wrap_o    = wrap;
   assign wrap_hi_o = wrap_hi;

endmodule

// File: rtl/dual_mode_timer.sv
module dual_mode_timer
   import tmr_pkg::*;
#(
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic [1:0]        ext_evt_i,
   input  logic [1:0]        gate_i,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data,
   output logic [1:0]        ovf_o
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("dual_mode_timer: SYNC_STAGES must be at least 2");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("dual_mode_timer: ADDR_W must be at least 3");
      end
   endgenerate

   logic [7:0]        mode_q;
   logic [NUM_CH-1:0] run_q, flag_q, ovf_q, hw_set;
   logic [NUM_CH-1:0] gate_lvl, ext_fall, step;
   logic [NUM_CH-1:0] wrap, wrap_hi;
   logic [7:0]        cnt_lo [NUM_CH];
   logic [7:0]        cnt_hi [NUM_CH];
   tmr_mode_e         ch_mode [NUM_CH];

   logic wr_mode, wr_ctrl;
   logic [3:0] unused_ctrl_lo;
   assign unused_ctrl_lo = wr_data[3:0];

   assign wr_mode = wr_en && (wr_addr == ADDR_W'(A_MODE));
   assign wr_ctrl = wr_en && (wr_addr == ADDR_W'(A_CTRL));

   logic split0;
   assign split0 = (ch_mode[0] == MD_SPLIT);

   genvar gi;
   generate
      for (gi = 0; gi < NUM_CH; gi++) begin : g_ch
         logic gate_bit, src_ext, gate_ok, src_ok;

         assign ch_mode[gi] = tmr_mode_e'(mode_q[4*gi +: 2]);
         assign src_ext     = mode_q[4*gi + 2];
         assign gate_bit    = mode_q[4*gi + 3];

         tmr_sync #(.STAGES(SYNC_STAGES)) i_gate_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .async_i(gate_i[gi]),
            .level_o(gate_lvl[gi])
         );

         tmr_edge_sampler #(.STAGES(SYNC_STAGES)) i_evt (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick_en(tick_en),
            .async_i(ext_evt_i[gi]),
            .fall_o (ext_fall[gi])
         );

         assign gate_ok  = ~gate_bit | gate_lvl[gi];
         assign src_ok   = ~src_ext | ext_fall[gi];
         assign step[gi] = tick_en & run_q[gi] & gate_ok & src_ok;

         tmr_channel #(.CAN_SPLIT(gi == 0)) i_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .mode_i   (ch_mode[gi]),
            .step_i   (step[gi]),
            .step_hi_i((gi == 0) ? (tick_en & run_q[1]) : 1'b0),
            .wr_lo_i  (wr_en && (wr_addr == ADDR_W'(A_C0L + 2*gi))),
            .wr_hi_i  (wr_en && (wr_addr == ADDR_W'(A_C0H + 2*gi))),
            .wdata_i  (wr_data),
            .lo_o     (cnt_lo[gi]),
            .hi_o     (cnt_hi[gi]),
            .wrap_o   (wrap[gi]),
            .wrap_hi_o(wrap_hi[gi])
         );

         // flag: hardware set beats a same-cycle software write
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               flag_q[gi] <= 1'b0;
               run_q[gi]  <= 1'b0;
            end else begin
               if (hw_set[gi])   flag_q[gi] <= 1'b1;
               else if (wr_ctrl) flag_q[gi] <= wr_data[CB_FLAG0 + 2*gi];
               if (wr_ctrl)      run_q[gi]  <= wr_data[CB_RUN0 + 2*gi];
            end
         end
      end
   endgenerate

   logic unused_wrap_hi1;
   assign unused_wrap_hi1 = wrap_hi[1];

   assign hw_set[0] = wrap[0];
   assign hw_set[1] = split0 ? wrap_hi[0] : wrap[1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= '0;
         ovf_q  <= '0;
      end else begin
         if (wr_mode) mode_q <= wr_data;
         ovf_q <= hw_set;
      end
   end

   assign ovf_o = ovf_q;

   always_comb begin
      rd_data = '0;
      unique case (rd_addr)
         ADDR_W'(A_MODE): rd_data = mode_q;
         ADDR_W'(A_CTRL): rd_data = {flag_q[1], run_q[1], flag_q[0], run_q[0], 4'b0000};
         ADDR_W'(A_C0L):  rd_data = cnt_lo[0];
         ADDR_W'(A_C0H):  rd_data = cnt_hi[0];
         ADDR_W'(A_C1L):  rd_data = cnt_lo[1];
         ADDR_W'(A_C1H):  rd_data = cnt_hi[1];
         default:         rd_data = '0;
      endcase
   end

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        tick_en,
   input logic        wr_en,
   input logic        ctrl_wr,
   input logic [7:0]  mode,
   input logic [1:0]  run,
   input logic [1:0]  flag,
   input logic [1:0]  ovf,
   input logic [15:0] c0,
   input logic [15:0] c1
);

   a_r12_pulse_flag0: assert property (@(posedge clk) disable iff (!rst_n)
      ovf[0] |-> flag[0]);

   a_r12_pulse_flag1: assert property (@(posedge clk) disable iff (!rst_n)
      ovf[1] |-> flag[1]);

   a_r12_no_pulse_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_en |=> (ovf == 2'b00));

   a_r3_flag0_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[0] && !ctrl_wr) |=> flag[0]);

   a_r3_flag1_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[1] && !ctrl_wr) |=> flag[1]);

   a_r2_no_tick_no_count: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en && !wr_en) |=> ($stable(c0) && $stable(c1)));

   a_r10_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!run[0] && !wr_en && mode[1:0] != 2'b11) |=> $stable(c0));

   a_r7_ch1_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[5:4] == 2'b11 && !wr_en) |=> $stable(c1));

endmodule

bind dual_mode_timer tmr_checker i_tmr_checker (
   .clk    (clk),
   .rst_n  (rst_n),
   .tick_en(tick_en),
   .wr_en  (wr_en),
   .ctrl_wr(wr_ctrl),
   .mode   (mode_q),
   .run    (run_q),
   .flag   (flag_q),
   .ovf    (ovf_q),
   .c0     ({cnt_hi[0], cnt_lo[0]}),
   .c1     ({cnt_hi[1], cnt_lo[1]})
);

// File: tb/test_dual_mode_timer.sv
module test_dual_mode_timer;

   localparam int AW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick_en = 1'b0;
   logic [1:0]    ext_evt_i = 2'b11;
   logic [1:0]    gate_i = 2'b00;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [7:0]    wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [7:0]    rd_data;
   logic [1:0]    ovf_o;

   int n_checks = 0;
   int n_fail   = 0;
   int n_ovf0   = 0;
   int n_ovf1   = 0;

   always #2.5 clk = ~clk;

   dual_mode_timer #(.ADDR_W(AW)) i_dual_mode_timer (
      .clk, .rst_n, .tick_en, .ext_evt_i, .gate_i,
      .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data, .ovf_o
   );

   always @(negedge clk) begin
      if (rst_n && ovf_o[0]) n_ovf0++;
      if (rst_n && ovf_o[1]) n_ovf1++;
   end

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d, input bit with_tick = 1'b0);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = 8'(d); tick_en = with_tick;
      @(negedge clk);
      wr_en = 1'b0; tick_en = 1'b0;
   endtask

   task automatic rd(input int a, output int d);
      @(negedge clk);
      rd_addr = AW'(a);
      #0.5 d = int'(rd_data);
   endtask

   task automatic rd16(input int lo_a, output int d);
      int lo, hi;
      rd(lo_a, lo);
      rd(lo_a + 1, hi);
      d = (hi << 8) | lo;
   endtask

   task automatic tick(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk) tick_en = 1'b1;
         @(negedge clk) tick_en = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      int v;
      for (int a = 0; a < 6; a++) begin
         rd(a, v);
         chk($sformatf("R1 reg %0d after reset", a), v, 0);
      end
      chk("R1 ovf_o after reset", int'(ovf_o), 0);
   endtask

   task automatic t_regmap;
      int v;
      wr(0, 'hA5); rd(0, v); chk("R11 mode readback", v, 'hA5);
      wr(1, 'hAF); rd(1, v); chk("R11 control flags writable, low nibble zero", v, 'hA0);
      rd(6, v);    chk("R11 unused address", v, 0);
      wr(1, 0); wr(0, 0);
   endtask

   task automatic t_w16;
      int v;
      wr(0, 'h01); wr(3, 'hFF); wr(2, 'hFD);
      n_ovf0 = 0;
      wr(1, 'h10);
      tick(2);
      rd16(2, v); chk("R2 16-bit count", v, 'hFFFF);
      rd(1, v);   chk("R2 no flag before wrap", v, 'h10);
      tick(1);
      rd16(2, v); chk("R2 16-bit wrap", v, 0);
      rd(1, v);   chk("R2 flag on wrap", v, 'h30);
      chk("R12 one pulse ch0", n_ovf0, 1);
      tick(3);
      rd16(2, v); chk("R3 counts on after overflow", v, 3);
      rd(1, v);   chk("R3 flag sticky", v, 'h30);
      wr(1, 'h00);
      rd(1, v);   chk("R3 software clear", v, 0);
      tick(4);
      rd16(2, v); chk("R10 stopped holds", v, 3);
      wr(3, 'hFF); wr(2, 'hFF);
      wr(1, 'h30);
      wr(1, 'h10, 1'b1);
      rd(1, v);   chk("R3 hardware set beats clear", v, 'h30);
      rd16(2, v); chk("R3 wrap in priority cycle", v, 0);
      wr(1, 0);
   endtask

   task automatic t_w13;
      int v;
      wr(0, 'h00); wr(3, 'h02); wr(2, 'hFF);
      wr(1, 'h10);
      tick(1);
      rd(3, v); chk("R4 carry into high", v, 'h03);
      rd(1, v); chk("R4 no flag on carry", v, 'h10);
      wr(1, 0);
      wr(3, 'hFF); wr(2, 'hFE);
      wr(1, 'h10);
      tick(2);
      rd(2, v); chk("R4 low after 13-bit wrap", v, 0);
      rd(3, v); chk("R4 high after 13-bit wrap keeps top 3 bits", v, 'hE0);
      rd(1, v); chk("R4 flag on 13-bit wrap", v, 'h30);
      wr(1, 0);
   endtask

   task automatic t_reload;
      int v;
      wr(0, 'h02); wr(3, 'h80); wr(2, 'hFE);
      wr(1, 'h10);
      tick(1);
      rd(2, v); chk("R5 low counting", v, 'hFF);
      tick(1);
      rd(2, v); chk("R5 low reloaded", v, 'h80);
      rd(3, v); chk("R5 high unchanged", v, 'h80);
      rd(1, v); chk("R5 flag on reload", v, 'h30);
      tick(2);
      rd(2, v); chk("R5 counting after reload", v, 'h82);
      wr(1, 0);
   endtask

   task automatic t_split;
      int v;
      wr(0, 'h13); wr(2, 'hFF); wr(3, 'hFE); wr(4, 'hFF); wr(5, 'hFF);
      n_ovf0 = 0; n_ovf1 = 0;
      wr(1, 'h10);
      tick(1);
      rd(2, v);   chk("R6 split low wrapped", v, 0);
      rd(3, v);   chk("R6 split high idle without run1", v, 'hFE);
      rd(1, v);   chk("R6 split low sets flag0", v, 'h30);
      rd16(4, v); chk("R10 ch1 stopped", v, 'hFFFF);
      wr(1, 'h40);
      tick(1);
      rd16(4, v); chk("R7 ch1 wrapped", v, 0);
      rd(1, v);   chk("R7 ch1 wrap leaves flag1 clear", v, 'h40);
      rd(2, v);   chk("R6 split low held by run0", v, 0);
      tick(1);
      rd(3, v);   chk("R6 split high wrapped", v, 0);
      rd(1, v);   chk("R6 split high sets flag1", v, 'hC0);
      chk("R12 ch1 pulse only from split high", n_ovf1, 1);
      chk("R12 ch0 pulse count", n_ovf0, 1);
      wr(1, 0);
      wr(0, 'h33); wr(4, 'h34); wr(5, 'h12);
      wr(1, 'h40);
      tick(3);
      rd16(4, v); chk("R7 ch1 in mode 11 frozen", v, 'h1234);
      rd(3, v);   chk("R6 split high counts on run1", v, 3);
      wr(1, 0);
   endtask

   task automatic t_gate;
      int v;
      wr(0, 'h09); wr(3, 0); wr(2, 0);
      gate_i[0] = 1'b0;
      wr(1, 'h10);
      idle(3); tick(4);
      rd16(2, v); chk("R8 gate low blocks", v, 0);
      gate_i[0] = 1'b1;
      idle(3); tick(5);
      rd16(2, v); chk("R8 gate high counts", v, 5);
      gate_i[0] = 1'b0;
      idle(3); tick(3);
      rd16(2, v); chk("R8 gate low stops again", v, 5);
      wr(0, 'h01);
      tick(2);
      rd16(2, v); chk("R8 gate ignored with enable 0", v, 7);
      wr(1, 0);
   endtask

   task automatic t_events;
      int v;
      wr(0, 'h50); wr(4, 0); wr(5, 0);
      ext_evt_i[1] = 1'b1;
      wr(1, 'h40);
      tick(4);
      rd16(4, v); chk("R9 no count on steady high", v, 0);
      ext_evt_i[1] = 1'b0;
      tick(1);
      rd16(4, v); chk("R9 edge not yet counted", v, 0);
      tick(2);
      rd16(4, v); chk("R9 first edge counted", v, 1);
      for (int e = 0; e < 2; e++) begin
         ext_evt_i[1] = 1'b1; tick(3);
         ext_evt_i[1] = 1'b0; tick(3);
      end
      rd16(4, v); chk("R9 one count per edge", v, 3);
      tick(6);
      rd16(4, v); chk("R9 steady low adds nothing", v, 3);
      ext_evt_i[1] = 1'b1;
      wr(1, 0);
   endtask

   initial begin
      idle(4);
      rst_n = 1'b1;
      t_reset();
      t_regmap();
      t_w16();
      t_w13();
      t_reload();
      t_split();
      t_gate();
      t_events();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule